// File: doc/BRIEF.md
# Vector Scatter-Gather Immediate Address Unit

This block runs one vector memory instruction of the scatter-gather kind. The per-lane base addresses come from a 128-bit source vector (Qm). A signed immediate is added to each base, and the unit can optionally write the resulting addresses back into Qm. The operation is split into four 32-bit beats, which are processed strictly in order from beat 0 to beat 3. For each beat that is executed, the unit forms an address and issues one 32-bit read or write on a valid/ready memory port. On a load, the returned word is merged into the destination vector (Qd).

Two 16-bit masks control the beats. A beat-execution mask can skip a beat entirely. A byte predicate mask zeroes a loaded lane or suppresses a store, but it has no effect on address writeback. There are two forms. In the word form, every lane addresses its own 32-bit word. In the doubleword form, each pair of lanes shares the even lane's base and covers eight consecutive bytes.

Commands enter on a valid/ready handshake, and `cmd_ready` stays low for as long as an instruction is in flight. The memory port follows the usual back-pressure rule: once a request is raised, its address, data, direction and strobe do not change until the cycle in which `mem_req_ready` is seen high. Results stay on `qd_out`/`qm_out` from the `done` pulse until the next accepted command.

Top module: `sgimm_unit`

## Requirements
- R1: The instruction word is decoded as follows: bit 20 = 1 for a load and 0 for a store; bit 21 = writeback enable; bit 23 = 1 to add the offset and 0 to subtract it; bits 6:0 = unsigned immediate; bits 11:8 = 4'b1110 for the word form and 4'b1111 for the doubleword form; bits 15:13 = Qd index; bits 19:17 = Qm index.
- R2: The byte offset is the immediate shifted left by 2 in the word form and by 3 in the doubleword form. It is negated when bit 23 is 0.
- R3: In the word form, beat e (0..3, issued in ascending order) addresses Qm lane e plus the offset, modulo 2^32. Lane e occupies bits 32e+31:32e.
- R4: In the doubleword form, beat e uses Qm lane (e with bit 0 cleared) plus the offset, plus 4 more bytes on odd beats. The lane value is always the one held before that pair's writeback.
- R5: The execution bit for beat e is bit 4e of `beat_mask`. When it is 0, the beat makes no memory access, leaves its Qd lane unchanged and writes back no address.
- R6: The predicate bit for beat e is bit 4e of `pred_mask`. For an executed beat with predicate 0, a load makes no access and writes zero into the Qd lane, and a store makes no write.
- R7: With writeback in the word form, every executed lane of Qm is replaced by its computed address, whatever its predicate bit.
- R8: With writeback in the doubleword form, only odd executed beats write back. They store (address - 4) into the even lane of the pair.
- R9: A load whose Qd index equals its Qm index, or a word whose bits 11:8 are neither 1110 nor 1111, is rejected. `illegal` pulses for one cycle after acceptance, no memory request is made, `done` stays low and `qd_out`/`qm_out` keep their values.
- R10: Requests hold address, data, direction and strobe until `mem_req_ready`. Writes use strobe 4'b1111. Load data is taken from `mem_rdata` one cycle after the request handshake.
- R11: `done` is a single-cycle pulse after beat 3 completes. `cmd_ready` is low from acceptance of a legal command through the `done` cycle.
- R12: Without writeback, `qm_out` equals `qm_in`. On a store, `qd_out` equals `qd_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted when valid |
| cmd_insn | input | 32 | Instruction word |
| qd_in | input | 128 | Destination/store-data vector |
| qm_in | input | 128 | Base-address vector |
| pred_mask | input | 16 | Byte predicate mask |
| beat_mask | input | 16 | Beat-execution mask |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, little-endian |
| mem_wstrb | output | 4 | Byte write strobes |
| mem_rdata | input | 32 | Read data, one cycle after handshake |
| qd_out | output | 128 | Resulting Qd |
| qm_out | output | 128 | Resulting Qm |
| done | output | 1 | Instruction completed |
| illegal | output | 1 | Command rejected |

## Verification
`illegal` is due in exactly the cycle after the accepting edge, and the bench samples it at the falling edge that follows that edge. `done` arrives a variable number of cycles later: one cycle per skipped or predicated-off beat, plus the back-pressure of the memory model, plus one data cycle per load. So the bench polls `done` at falling edges rather than waiting a fixed count, then compares `qd_out`/`qm_out` and the logged access sequence. The memory model records a handshake at the falling edge before the rising edge on which it completes, and drives read data at the next falling edge, so that data is in place when the unit captures it.

// File: rtl/sgimm_pkg.sv
package sgimm_pkg;
  localparam int SG_IMM_W = 7;
  localparam int SG_QIDX_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BEAT,
    ST_REQ,
    ST_RDATA,
    ST_DONE
  } sg_state_e;

  typedef struct packed {
    logic                 is_load;
    logic                 wb;
    logic                 add;
    logic                 dword;
    logic                 form_ok;
    logic [SG_IMM_W-1:0]  imm;
    logic [SG_QIDX_W-1:0] qd_idx;
    logic [SG_QIDX_W-1:0] qm_idx;
  } sg_cmd_t;
endpackage

// File: rtl/sgimm_decode.sv
module sgimm_decode
  import sgimm_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic [31:0]       insn,
  output sg_cmd_t           cmd,
  output logic [LANE_W-1:0] offset,
  output logic              reject
);
  logic [LANE_W-1:0] mag;
  logic unused_bits;

  assign unused_bits = ^{insn[31:24], insn[22], insn[16], insn[12], insn[7]};

  always_comb begin
    cmd.is_load = insn[20];
    cmd.wb      = insn[21];
    cmd.add     = insn[23];
    cmd.form_ok = (insn[11:9] == 3'b111);
    cmd.dword   = insn[8];
    cmd.imm     = insn[SG_IMM_W-1:0];
    cmd.qd_idx  = insn[15:13];
    cmd.qm_idx  = insn[19:17];
  end

  // scale by element size, then apply the direction
  always_comb begin
    mag = '0;
    mag[SG_IMM_W-1:0] = cmd.imm;
    mag = cmd.dword ? (mag << 3) : (mag << 2);
    offset = cmd.add ? mag : (LANE_W'(0) - mag);
  end

  assign reject = !cmd.form_ok || (cmd.is_load && (cmd.qd_idx == cmd.qm_idx));
endmodule

// File: rtl/sgimm_beat_addr.sv
module sgimm_beat_addr #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  localparam int BEAT_W = $clog2(LANES)
) (
  input  logic [LANES-1:0][LANE_W-1:0] qm,
  input  logic [BEAT_W-1:0]            beat,
  input  logic                         dword,
  input  logic                         wb,
  input  logic [LANE_W-1:0]            offset,
  output logic [LANE_W-1:0]            addr,
  output logic                         wb_en,
  output logic [BEAT_W-1:0]            wb_lane,
  output logic [LANE_W-1:0]            wb_value
);
  logic [BEAT_W-1:0] base_lane;
  logic [LANE_W-1:0] base_sum;

  always_comb begin
    base_lane = beat;
    if (dword) base_lane[0] = 1'b0;
    base_sum = qm[base_lane] + offset;
    addr     = base_sum + ((dword && beat[0]) ? LANE_W'(4) : LANE_W'(0));
    wb_lane  = base_lane;
    wb_value = base_sum;
    wb_en    = wb && (!dword || beat[0]);
  end
endmodule

// File: rtl/sgimm_unit.sv
module sgimm_unit
  import sgimm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  localparam int VEC_W  = LANES * LANE_W,
  localparam int MASK_W = VEC_W / 8,
  localparam int STRIDE = MASK_W / LANES,
  localparam int BEAT_W = $clog2(LANES),
  localparam int STRB_W = LANE_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_insn,
  input  logic [VEC_W-1:0]  qd_in,
  input  logic [VEC_W-1:0]  qm_in,
  input  logic [MASK_W-1:0] pred_mask,
  input  logic [MASK_W-1:0] beat_mask,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [LANE_W-1:0] mem_addr,
  output logic [LANE_W-1:0] mem_wdata,
  output logic [STRB_W-1:0] mem_wstrb,
  input  logic [LANE_W-1:0] mem_rdata,
  output logic [VEC_W-1:0]  qd_out,
  output logic [VEC_W-1:0]  qm_out,
  output logic              done,
  output logic              illegal
);
  sg_state_e                   state;
  sg_cmd_t                     dec_cmd, cmd_q;
  logic [LANE_W-1:0]           dec_off, off_q;
  logic                        dec_reject;
  logic [BEAT_W-1:0]           beat;
  logic [LANES-1:0][LANE_W-1:0] qd_r, qm_r;
  logic [LANES-1:0]            exec_bits, pred_bits;
  logic [MASK_W-1:0]           pred_q, eci_q;
  logic [LANE_W-1:0]           req_addr, req_wdata;
  logic                        req_we, illegal_q;
  logic [LANE_W-1:0]           beat_addr, wb_value;
  logic                        wb_en;
  logic [BEAT_W-1:0]           wb_lane;
  logic                        last_beat;

  sgimm_decode #(.LANE_W(LANE_W)) u_dec (
    .insn(cmd_insn), .cmd(dec_cmd), .offset(dec_off), .reject(dec_reject)
  );

  sgimm_beat_addr #(.LANES(LANES), .LANE_W(LANE_W)) u_addr (
    .qm(qm_r), .beat(beat), .dword(cmd_q.dword), .wb(cmd_q.wb),
    .offset(off_q), .addr(beat_addr), .wb_en(wb_en),
    .wb_lane(wb_lane), .wb_value(wb_value)
  );

  // per-beat control bits sit at the first byte of each beat
  for (genvar g = 0; g < LANES; g++) begin : g_beat_bits
    assign exec_bits[g] = eci_q[g*STRIDE];
    assign pred_bits[g] = pred_q[g*STRIDE];
  end

  assign last_beat = (beat == BEAT_W'(LANES-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      beat      <= '0;
      cmd_q     <= '0;
      off_q     <= '0;
      qd_r      <= '0;
      qm_r      <= '0;
      pred_q    <= '0;
      eci_q     <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_we    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (dec_reject) begin
              illegal_q <= 1'b1;
            end else begin
              cmd_q  <= dec_cmd;
              off_q  <= dec_off;
              qd_r   <= qd_in;
              qm_r   <= qm_in;
              pred_q <= pred_mask;
              eci_q  <= beat_mask;
              beat   <= '0;
              state  <= ST_BEAT;
            end
          end
        end
        ST_BEAT: begin
          if (exec_bits[beat]) begin
            if (wb_en) qm_r[wb_lane] <= wb_value;
            if (pred_bits[beat]) begin
              req_addr  <= beat_addr;
              req_we    <= !cmd_q.is_load;
              req_wdata <= qd_r[beat];
              state     <= ST_REQ;
            end else begin
              if (cmd_q.is_load) qd_r[beat] <= '0;
              if (last_beat) state <= ST_DONE;
              else beat <= beat + 1'b1;
            end
          end else begin
            if (last_beat) state <= ST_DONE;
            else beat <= beat + 1'b1;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            if (!req_we) begin
              state <= ST_RDATA;
            end else if (last_beat) begin
              state <= ST_DONE;
            end else begin
              beat  <= beat + 1'b1;
              state <= ST_BEAT;
            end
          end
        end
        ST_RDATA: begin
          qd_r[beat] <= mem_rdata;
          if (last_beat) begin
            state <= ST_DONE;
          end else begin
            beat  <= beat + 1'b1;
            state <= ST_BEAT;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_we        = req_we;
  assign mem_addr      = req_addr;
  assign mem_wdata     = req_wdata;
  assign mem_wstrb     = req_we ? '1 : '0;
  assign qd_out        = qd_r;
  assign qm_out        = qm_r;
  assign done          = (state == ST_DONE);
  assign illegal       = illegal_q;
endmodule

// File: rtl/sgimm_chk.sv
module sgimm_chk #(
  parameter int LANE_W = 32,
  parameter int STRB_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_we,
  input logic [LANE_W-1:0] mem_addr,
  input logic [LANE_W-1:0] mem_wdata,
  input logic [STRB_W-1:0] mem_wstrb,
  input logic              done,
  input logic              illegal
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_wdata) && $stable(mem_we));

  // R10
  full_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we |-> mem_wstrb == {STRB_W{1'b1}});

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || done) |-> !cmd_ready);

  // R9
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req_valid && !done);
endmodule

bind sgimm_unit sgimm_chk #(.LANE_W(LANE_W), .STRB_W(STRB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_wstrb(mem_wstrb), .done(done), .illegal(illegal)
);

// File: tb/test_sgimm_unit.sv
module test_sgimm_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [31:0]  cmd_insn = '0;
  logic [127:0] qd_in = '0, qm_in = '0;
  logic [15:0]  pred_mask = '0, beat_mask = '0;
  logic         mem_req_valid, mem_req_ready = 1'b0, mem_we;
  logic [31:0]  mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]   mem_wstrb;
  logic [127:0] qd_out, qm_out;
  logic         done, illegal;

  int checks = 0, failures = 0, cycles = 0;

  sgimm_unit i_sgimm_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_insn(cmd_insn), .qd_in(qd_in), .qm_in(qm_in), .pred_mask(pred_mask),
    .beat_mask(beat_mask), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
    .qd_out(qd_out), .qm_out(qm_out), .done(done), .illegal(illegal)
  );

  always #5 clk = ~clk;

  // memory model and access log
  logic [31:0] log_addr [8];
  logic [31:0] log_data [8];
  logic        log_we   [8];
  int          log_n = 0;
  logic        rd_pend = 1'b0;
  logic [31:0] rd_addr = '0;
  int          ready_pct = 60;

  function automatic logic [31:0] rd_model(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rd_pend) begin
      mem_rdata = rd_model(rd_addr);
      rd_pend = 1'b0;
    end else begin
      mem_rdata = $urandom;
    end
    mem_req_ready = (($urandom % 100) < ready_pct);
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (log_n < 8) begin
        log_addr[log_n] = mem_addr;
        log_data[log_n] = mem_wdata;
        log_we[log_n]   = mem_we;
      end
      log_n++;
      if (!mem_we) begin
        rd_pend = 1'b1;
        rd_addr = mem_addr;
      end
    end
  end

  // expected model
  logic [127:0] e_qd, e_qm;
  logic [31:0]  e_addr [4];
  logic [31:0]  e_data [4];
  logic         e_we   [4];
  int           e_n;
  logic         e_ill;

  task automatic model(input logic [31:0] insn, input logic [127:0] qd,
                       input logic [127:0] qm, input logic [15:0] pm,
                       input logic [15:0] bm);
    logic ld, wb, dw;
    logic [31:0] off, base, a;
    int bl;
    ld = insn[20]; wb = insn[21]; dw = insn[8];
    off = dw ? ({25'd0, insn[6:0]} << 3) : ({25'd0, insn[6:0]} << 2);
    if (!insn[23]) off = -off;
    e_ill = (insn[11:9] != 3'b111) || (ld && insn[15:13] == insn[19:17]);
    e_n = 0;
    e_qd = qd; e_qm = qm;
    if (e_ill) return;
    for (int e = 0; e < 4; e++) begin
      if (!bm[4*e]) continue;
      bl = dw ? (e & 2) : e;
      base = e_qm[32*bl +: 32];
      a = base + off + ((dw && (e & 1) != 0) ? 32'd4 : 32'd0);
      if (pm[4*e]) begin
        e_addr[e_n] = a; e_we[e_n] = !ld; e_data[e_n] = qd[32*e +: 32];
        e_n++;
        if (ld) e_qd[32*e +: 32] = rd_model(a);
      end else if (ld) begin
        e_qd[32*e +: 32] = 32'd0;
      end
      if (wb && (!dw || (e & 1) != 0)) e_qm[32*bl +: 32] = base + off;
    end
  endtask

  function automatic logic [31:0] mk(input logic ld, input logic wb,
      input logic add, input logic dw, input logic [6:0] imm,
      input logic [2:0] qd, input logic [2:0] qm);
    return {8'hFD, add, 1'b0, wb, ld, qm, 1'b0, qd, 1'b1, 3'b111, dw, 1'b0, imm};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] insn, input logic [127:0] qd,
                     input logic [127:0] qm, input logic [15:0] pm,
                     input logic [15:0] bm, input string req);
    int w;
    model(insn, qd, qm, pm, bm);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    log_n = 0;
    cmd_insn = insn; qd_in = qd; qm_in = qm; pred_mask = pm; beat_mask = bm;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    // R9: illegal flag is due at this falling edge
    check(illegal == e_ill, req, "R9 illegal", {127'd0, illegal}, {127'd0, e_ill});
    if (e_ill) begin
      repeat (3) @(negedge clk);
      check(log_n == 0 && !done, req, "R9 no access", log_n, 0);
    end else begin
      w = 0;
      while (!done && w < 400) begin
        @(negedge clk);
        w++;
      end
      if (!done) check(1'b0, req, "watchdog done", 0, 1);
      check(qd_out == e_qd, req, "qd_out", qd_out, e_qd);
      check(qm_out == e_qm, req, "qm_out", qm_out, e_qm);
      check(log_n == e_n, req, "access count", log_n, e_n);
      for (int k = 0; k < e_n && k < log_n; k++) begin
        check(log_addr[k] == e_addr[k] && log_we[k] == e_we[k] &&
              (!e_we[k] || log_data[k] == e_data[k]), req, "access",
              {63'd0, log_we[k], log_addr[k], log_data[k]},
              {63'd0, e_we[k], e_addr[k], e_data[k]});
      end
      @(negedge clk);
      check(!done && cmd_ready, "R11", "done single pulse", {126'd0, done, cmd_ready}, 1);
    end
  endtask

  function automatic logic [127:0] rv();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] q;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !mem_req_valid && !done && !illegal && qd_out == 0 && qm_out == 0,
          "R11", "reset state", {cmd_ready, mem_req_valid, done, illegal}, 4'b1000);

    q = {32'h4000_0300, 32'h4000_0200, 32'h4000_0100, 32'h4000_0000};
    // R1 R3 word load add, no writeback, all beats
    run(mk(1, 0, 1, 0, 7'd5, 3'd1, 3'd2), rv(), q, 16'hFFFF, 16'hFFFF, "R3");
    // R2 R7 word store subtract with writeback, predicate partly off
    run(mk(0, 1, 0, 0, 7'd3, 3'd4, 3'd5), rv(), q, 16'h0F0F, 16'hFFFF, "R7");
    // R4 R8 doubleword load add with writeback
    run(mk(1, 1, 1, 1, 7'd2, 3'd0, 3'd3), rv(), q, 16'hFFFF, 16'hFFFF, "R8");
    // R5 beats 1 and 2 skipped, word store writeback
    run(mk(0, 1, 1, 0, 7'd1, 3'd2, 3'd6), rv(), q, 16'hFFFF, 16'hF00F, "R5");
    // R6 load with predicate off zeroes lanes
    run(mk(1, 0, 1, 0, 7'd9, 3'd3, 3'd1), {4{32'hDEAD_BEEF}}, q, 16'h00F0, 16'hFFFF, "R6");
    // R8 doubleword store, odd beat skipped: no writeback for that pair
    run(mk(0, 1, 0, 1, 7'd127, 3'd7, 3'd0), rv(), q, 16'hFFFF, 16'h0FFF, "R8");
    // R3 wrap past 2^32
    run(mk(1, 1, 1, 0, 7'd127, 3'd5, 3'd6), rv(), {4{32'hFFFF_FFF0}}, 16'hFFFF, 16'hFFFF, "R3");
    // R9 load with Qd == Qm rejected
    run(mk(1, 1, 1, 0, 7'd4, 3'd2, 3'd2), rv(), rv(), 16'hFFFF, 16'hFFFF, "R9");
    // R9 store with Qd == Qm accepted
    run(mk(0, 0, 1, 1, 7'd4, 3'd2, 3'd2), rv(), q, 16'hFFFF, 16'hFFFF, "R9");
    // R9 bad form bits rejected
    run(mk(1, 0, 1, 0, 7'd4, 3'd1, 3'd2) & ~32'h0000_0200, rv(), rv(), 16'hFFFF, 16'hFFFF, "R9");
    // R12 no beats executed: outputs equal inputs
    run(mk(1, 1, 1, 1, 7'd4, 3'd1, 3'd2), rv(), q, 16'hFFFF, 16'h0000, "R12");
    // R10 heavy back-pressure
    ready_pct = 15;
    run(mk(1, 0, 0, 1, 7'd33, 3'd6, 3'd4), rv(), rv(), 16'hFFFF, 16'hFFFF, "R10");
    run(mk(0, 1, 1, 0, 7'd33, 3'd6, 3'd4), rv(), rv(), 16'hFFFF, 16'hFFFF, "R10");
    ready_pct = 60;
    // random mix covering R1..R12
    for (int n = 0; n < 60; n++) begin
      run(mk($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, 7'($urandom),
             3'($urandom), 3'($urandom)), rv(), rv(), 16'($urandom), 16'($urandom), "R1");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule